// File: doc/BRIEF.md
# Selectable-Order PRBS Pattern Generator

This block produces a pseudo-random serial bit stream for exercising links and channels. It is a Fibonacci linear feedback shift register whose length is picked from four maximal-length polynomials: 5, 7, 23 or 31 stages. The feedback can be plain XOR or its complement, XNOR. Each enabled cycle it emits one bit and advances its state. The full state word is also visible, so a receiver or a test harness can align to it.

The polynomial order and the feedback mode are sampled only on the first clock after reset or on a seed load. Changing either input mid-stream therefore never mixes a partial state from one order into another. Each feedback mode has one state from which the register cannot move: all zeros for XOR, all ones for XNOR. The block substitutes a safe default seed whenever that state is requested or reached, and it raises a sticky flag when it does so.

Top module: `prbs_gen`

## Requirements
- R1: When advancing, the next state is ((state << 1) | fb) restricted to the low n bits. fb is state[hi] ^ state[lo], inverted when xnor_i was 1 at capture time. The order_i encodings and their taps are: 0 is n=5 with taps 4,2; 1 is n=7 with taps 6,5; 2 is n=23 with taps 22,17; 3 is n=31 with taps 30,27.
- R2: bit_o equals bit n-1 of the current state, that is, the bit that leaves the register on the next advance.
- R3: With en_i low and no load, the state holds its value.
- R4: In XOR mode the sequence returns to its start after exactly 2^n-1 advances and never passes through all zeros (checked for n=5 and n=7).
- R5: In XNOR mode the all-zeros state is a legal member of the sequence, the period is 2^n-1, and the all-ones state is never visited.
- R6: While rst_ni is low, state_o equals the default seed (1) and recovered_o is 0. On the first clock after release, order_i and xnor_i are captured and the state does not advance, whatever en_i is.
- R7: With load_i high at a clock edge, the state takes seed_i restricted to the low n bits of the newly captured order_i, and xnor_i is captured. A load takes priority over en_i.
- R8: A loaded seed whose active bits equal the lock-up pattern of the new mode (all zeros for XOR, all ones for XNOR) is replaced by the default seed 1, and recovered_o goes high.
- R9: recovered_o stays high until reset. The state never rests on the lock-up pattern: if its active bits match it, the next state is the default seed and the flag is set.
- R10: Changing order_i or xnor_i without a load or reset has no effect on the sequence.
- R11: In XOR mode at n=5, the longest run of ones in bit_o is 5 and the longest run of zeros is 4.
- R12: State bits at and above bit n always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Advance the sequence this cycle |
| order_i | input | 2 | Polynomial order select (0:5, 1:7, 2:23, 3:31) |
| xnor_i | input | 1 | 1 selects XNOR feedback, 0 selects XOR |
| load_i | input | 1 | Load seed_i and capture order/mode |
| seed_i | input | 31 | Seed word |
| bit_o | output | 1 | Serial output bit |
| state_o | output | 31 | Current register contents |
| recovered_o | output | 1 | Sticky flag: lock-up pattern was substituted |

## Verification
The bench uses the only build of the block, with the default seed of 1 and all 31 stages. This means every order is reachable at run time through order_i. The short orders, 5 and 7, make full periods affordable, so period length, zero exclusion and run lengths can be checked exhaustively. The 23- and 31-stage orders are compared against an independent model over a few hundred steps from several seeds, in both feedback modes.

// File: rtl/prbs_pkg.sv
package prbs_pkg;
  localparam int MAX_W   = 31;
  localparam int N_ORDER = 4;

  typedef enum logic [1:0] {ORD5 = 2'd0, ORD7 = 2'd1, ORD23 = 2'd2, ORD31 = 2'd3} prbs_order_e;

  function automatic int order_len(int idx);
    case (idx)
      0:       return 5;
      1:       return 7;
      2:       return 23;
      default: return 31;
    endcase
  endfunction

  function automatic int tap_lo(int idx);
    case (idx)
      0:       return 2;
      1:       return 5;
      2:       return 17;
      default: return 27;
    endcase
  endfunction

  function automatic logic [MAX_W-1:0] order_mask(prbs_order_e o);
    return {MAX_W{1'b1}} >> (MAX_W - order_len(int'(o)));
  endfunction
endpackage

// File: rtl/prbs_feedback.sv
module prbs_feedback #(
  parameter int W = prbs_pkg::MAX_W
) (
  input  logic [W-1:0]          state_i,
  input  prbs_pkg::prbs_order_e order_i,
  input  logic                  xnor_i,
  output logic                  fb_o,
  output logic                  msb_o
);
  logic [prbs_pkg::N_ORDER-1:0] fb_v, msb_v;

  for (genvar g = 0; g < prbs_pkg::N_ORDER; g++) begin : g_ord
    localparam int N  = prbs_pkg::order_len(g);
    localparam int LO = prbs_pkg::tap_lo(g);
    assign fb_v[g]  = state_i[N-1] ^ state_i[LO];
    assign msb_v[g] = state_i[N-1];
  end

  assign fb_o  = fb_v[order_i] ^ xnor_i;  // xnor == inverted xor
  assign msb_o = msb_v[order_i];
endmodule

// File: rtl/prbs_lock_detect.sv
module prbs_lock_detect #(
  parameter int W = prbs_pkg::MAX_W
) (
  input  logic [W-1:0] word_i,
  input  logic [W-1:0] mask_i,
  input  logic         xnor_i,
  output logic         lock_o
);
  logic [W-1:0] act;
  assign act    = word_i & mask_i;
  assign lock_o = xnor_i ? (act == mask_i) : (act == '0);
endmodule

// File: rtl/prbs_gen.sv
module prbs_gen #(
  parameter logic [prbs_pkg::MAX_W-1:0] DFLT_SEED = 31'd1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      en_i,
  input  logic [1:0]                order_i,
  input  logic                      xnor_i,
  input  logic                      load_i,
  input  logic [prbs_pkg::MAX_W-1:0] seed_i,
  output logic                      bit_o,
  output logic [prbs_pkg::MAX_W-1:0] state_o,
  output logic                      recovered_o
);
  import prbs_pkg::*;
  localparam int W = MAX_W;

  logic [W-1:0]  state_q, cur_mask, new_mask, seed_m, next_state;
  prbs_order_e   ord_q, ord_in;
  logic          xnor_q, init_q, flag_q;
  logic          fb, msb, lock_now, seed_lock;

  assign ord_in   = prbs_order_e'(order_i);
  assign cur_mask = order_mask(ord_q);
  assign new_mask = order_mask(ord_in);
  assign seed_m   = seed_i & new_mask;

  prbs_feedback #(.W(W)) u_fb (
    .state_i(state_q), .order_i(ord_q), .xnor_i(xnor_q), .fb_o(fb), .msb_o(msb)
  );

  prbs_lock_detect #(.W(W)) u_lock_state (
    .word_i(state_q), .mask_i(cur_mask), .xnor_i(xnor_q), .lock_o(lock_now)
  );

  prbs_lock_detect #(.W(W)) u_lock_seed (
    .word_i(seed_i), .mask_i(new_mask), .xnor_i(xnor_i), .lock_o(seed_lock)
  );

  assign next_state = ((state_q << 1) | W'(fb)) & cur_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= DFLT_SEED;
      ord_q   <= ORD5;
      xnor_q  <= 1'b0;
      init_q  <= 1'b0;
      flag_q  <= 1'b0;
    end else if (load_i || !init_q) begin
      // config only changes here: first cycle after reset or a seed load
      ord_q  <= ord_in;
      xnor_q <= xnor_i;
      init_q <= 1'b1;
      if (load_i) begin
        state_q <= seed_lock ? (DFLT_SEED & new_mask) : seed_m;
        if (seed_lock) flag_q <= 1'b1;
      end
    end else if (lock_now) begin
      state_q <= DFLT_SEED & cur_mask;
      flag_q  <= 1'b1;
    end else if (en_i) begin
      state_q <= next_state;
    end
  end

  assign bit_o       = msb;
  assign state_o     = state_q;
  assign recovered_o = flag_q;

  // R9
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recovered_o |=> recovered_o);

  // R9
  lockup_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_q |-> !lock_now);

  // R3
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_q && !load_i && !en_i && !lock_now) |=> $stable(state_q));

  // R1
  shift_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_q && en_i && !load_i && !lock_now) |=> state_q[0] == $past(fb));

  // R12
  upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q & ~cur_mask) == '0);
endmodule

// File: tb/prbs_gen_test.sv
module prbs_gen_test;
  localparam int W = 31;

  logic clk = 1'b0;
  logic rst_ni = 1'b0, en_i = 1'b0, xnor_i = 1'b0, load_i = 1'b0;
  logic [1:0] order_i = 2'd0;
  logic [W-1:0] seed_i = '0;
  logic bit_o, recovered_o;
  logic [W-1:0] state_o;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  prbs_gen uut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .order_i(order_i), .xnor_i(xnor_i),
    .load_i(load_i), .seed_i(seed_i), .bit_o(bit_o), .state_o(state_o),
    .recovered_o(recovered_o)
  );

  typedef struct packed {
    logic [1:0]  ord;
    logic        xn;
    logic [30:0] seed;
    logic [15:0] steps;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{2'd0, 1'b0, 31'h0000001F, 16'd40},
    '{2'd1, 1'b0, 31'h00000055, 16'd150},
    '{2'd2, 1'b0, 31'h00001234, 16'd300},
    '{2'd3, 1'b0, 31'h7ABCDEF0, 16'd300},
    '{2'd0, 1'b1, 31'h00000000, 16'd40},
    '{2'd3, 1'b1, 31'h00000000, 16'd300},
    '{2'd2, 1'b1, 31'h007FFFF0, 16'd200}
  };

  function automatic int mlen(logic [1:0] o);
    case (o) 2'd0: return 5; 2'd1: return 7; 2'd2: return 23; default: return 31; endcase
  endfunction
  function automatic int mlo(logic [1:0] o);
    case (o) 2'd0: return 2; 2'd1: return 5; 2'd2: return 17; default: return 27; endcase
  endfunction
  function automatic logic [W-1:0] mmask(logic [1:0] o);
    return {W{1'b1}} >> (W - mlen(o));
  endfunction
  function automatic logic [W-1:0] mstep(logic [W-1:0] s, logic [1:0] o, logic xn);
    logic f;
    f = s[mlen(o)-1] ^ s[mlo(o)] ^ xn;
    return ((s << 1) | W'(f)) & mmask(o);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic do_load(input logic [1:0] o, input logic xn, input logic [W-1:0] s);
    order_i = o; xnor_i = xn; seed_i = s; load_i = 1'b1;
    tick();
    load_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] m;
    int mism, cnt, run, max1, max0;
    bit zero_seen, ones_seen, prev;

    // R6 reset state
    @(negedge clk);
    chk(state_o == 31'd1, "R6 reset state", state_o, 1);
    chk(recovered_o == 1'b0, "R6 reset flag", recovered_o, 0);
    order_i = 2'd1; xnor_i = 1'b0; en_i = 1'b1;
    do_reset();
    tick();
    chk(state_o == 31'd1, "R6 no advance on capture cycle", state_o, 1);
    tick();
    chk(state_o == 31'd2, "R6 captured order 7 xor", state_o, 2);

    // R1 R2 R7 vector table
    foreach (VECS[i]) begin
      en_i = 1'b1;
      do_load(VECS[i].ord, VECS[i].xn, VECS[i].seed);
      m = VECS[i].seed & mmask(VECS[i].ord);
      chk(state_o == m, "R7 seed load", state_o, m);
      mism = 0;
      for (int k = 0; k < int'(VECS[i].steps); k++) begin
        if (bit_o !== m[mlen(VECS[i].ord)-1]) mism++;
        tick();
        m = mstep(m, VECS[i].ord, VECS[i].xn);
        if (state_o !== m) mism++;
      end
      chk(mism == 0, "R1 R2 sequence vs model", mism, 0);
    end

    // R3 hold
    do_load(2'd2, 1'b0, 31'h00ABCDE);
    en_i = 1'b0;
    repeat (5) tick();
    chk(state_o == 31'h00ABCDE, "R3 hold with en low", state_o, 31'h00ABCDE);
    en_i = 1'b1;

    // R7 load beats enable, upper seed bits dropped (R12)
    do_load(2'd0, 1'b0, 31'h7FFFFFE5);
    chk(state_o == 31'h5, "R7 R12 load masked", state_o, 5);

    // R4 R11 order 5 xor period and runs
    do_load(2'd0, 1'b0, 31'd1);
    cnt = 0; zero_seen = 0; run = 0; max1 = 0; max0 = 0; prev = bit_o;
    for (int k = 0; k < 62; k++) begin
      if (bit_o == prev) run++; else run = 1;
      prev = bit_o;
      if (bit_o && run > max1) max1 = run;
      if (!bit_o && run > max0) max0 = run;
      tick();
      if (state_o == '0) zero_seen = 1;
      if (cnt == 0 && state_o == 31'd1) cnt = k + 1;
    end
    chk(cnt == 31, "R4 order5 xor period", cnt, 31);
    chk(!zero_seen, "R4 order5 xor no zero", zero_seen, 0);
    chk(max1 == 5, "R11 longest ones run", max1, 5);
    chk(max0 == 4, "R11 longest zeros run", max0, 4);

    // R4 order 7 xor
    do_load(2'd1, 1'b0, 31'd1);
    cnt = 0; zero_seen = 0;
    for (int k = 0; k < 200 && cnt == 0; k++) begin
      tick();
      if (state_o == '0) zero_seen = 1;
      if (state_o == 31'd1) cnt = k + 1;
    end
    chk(cnt == 127, "R4 order7 xor period", cnt, 127);
    chk(!zero_seen, "R4 order7 xor no zero", zero_seen, 0);

    // R5 order 7 xnor from zero
    do_load(2'd1, 1'b1, 31'd0);
    chk(state_o == '0 && !recovered_o, "R5 zero seed legal in xnor", state_o, 0);
    cnt = 0; ones_seen = 0;
    for (int k = 0; k < 200 && cnt == 0; k++) begin
      tick();
      if (state_o == 31'h7F) ones_seen = 1;
      if (state_o == '0) cnt = k + 1;
    end
    chk(cnt == 127, "R5 order7 xnor period", cnt, 127);
    chk(!ones_seen, "R5 all-ones never visited", ones_seen, 0);

    // R10 order/mode change without load
    do_load(2'd0, 1'b0, 31'h13);
    m = 31'h13;
    order_i = 2'd3; xnor_i = 1'b1;
    mism = 0;
    for (int k = 0; k < 12; k++) begin
      tick();
      m = mstep(m, 2'd0, 1'b0);
      if (state_o !== m) mism++;
    end
    chk(mism == 0, "R10 config change ignored", mism, 0);
    chk((state_o & ~31'h1F) == '0, "R12 upper bits zero", state_o, m);

    // R8 lock-up seeds
    chk(recovered_o == 1'b0, "R9 flag clear before substitution", recovered_o, 0);
    do_load(2'd2, 1'b0, 31'h7F800000);
    chk(state_o == 31'd1, "R8 xor zero seed replaced", state_o, 1);
    chk(recovered_o == 1'b1, "R8 flag set", recovered_o, 1);
    do_load(2'd1, 1'b1, 31'h0000007F);
    chk(state_o == 31'd1, "R8 xnor ones seed replaced", state_o, 1);

    // R9 sticky until reset
    do_load(2'd3, 1'b0, 31'h1234567);
    repeat (10) tick();
    chk(recovered_o == 1'b1, "R9 flag sticky", recovered_o, 1);
    do_reset();
    @(negedge clk);
    chk(recovered_o == 1'b0, "R9 flag cleared by reset", recovered_o, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule